// File: doc/BRIEF.md
# DRAM Command Launch Timing Stage

This block takes one DRAM command at a time from an upstream scheduler over a valid/ready handshake and places it on the DRAM command, address, bank and chip-select pins. The command and address can be stretched across one, two or three clocks, as set by two timing-mode inputs. During a stretched launch the chip select is strobed low only in the final clock. The extra clocks give heavily loaded address lines time to settle before the DRAM latches them.

The block also checks the static configuration as a whole: timing mode, bus width, burst length and memory type. When the fields break a cross-field rule, it raises a sticky error flag and stops accepting commands until the configuration is legal again. The scheduler sees `cmd_ready` high only in the last clock of a launch window, or while no window is running. Commands can therefore follow each other with no idle gap, and the address never changes in the middle of a window.

Top module: `dram_cmd_launch`

## Requirements
- R1: With both timing-mode inputs low (1T), an accepted command appears on the pins in the clock after the accepting edge, for exactly one clock, with its chip select asserted in that clock.
- R2: With `cfg_t2` high (2T), the command, address and bank stay on the pins for two clocks, and chip select is asserted only in the second clock.
- R3: With `cfg_t3` high (3T), the command, address and bank stay on the pins for three clocks, and chip select is asserted only in the third clock.
- R4: `cmd_ready` is low in every clock of a launch window except the last. In the last clock, or when no window is active, it is high if the configuration is legal, so back-to-back commands launch with no idle clock.
- R5: Outside launch windows, `dram_cs_n` is all ones and `dram_cmd` holds the idle value (all ones). In the strobe clock, only bit i of `dram_cs_n` is low, where i is the chip-select index that came with the command.
- R6: Setting `cfg_t2` and `cfg_t3` together is illegal.
- R7: 2T or 3T timing together with a 32-bit bus (`cfg_bus32`=1) and 4-beat bursts (`cfg_burst8`=0) is illegal. The same timing with 8-beat bursts is legal.
- R8: Memory type 3'b011 (DDR2) with 8-beat bursts (`cfg_burst8`=1) is illegal, whatever the bus width.
- R9: Memory type 3'b111 (DDR3) needs `cfg_burst8`=1 when `cfg_bus32`=1 and `cfg_burst8`=0 when `cfg_bus32`=0. Any other pairing is illegal.
- R10: While the configuration is illegal, `cmd_ready` is low and no command reaches the pins. `cfg_error` rises at the next clock edge and stays high until reset, even after the configuration is legal again.
- R11: A synchronous active-low reset puts all of `dram_cs_n` high, puts `dram_cmd` at the idle value, clears `cfg_error` and ends any window, so that `cmd_ready` is high under a legal configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_t2 | input | 1 | Two-clock launch enable |
| cfg_t3 | input | 1 | Three-clock launch enable |
| cfg_bus32 | input | 1 | Bus width: 0 = 64-bit, 1 = 32-bit |
| cfg_burst8 | input | 1 | Burst length: 0 = 4-beat, 1 = 8-beat |
| cfg_memtype | input | 3 | Memory type code (3'b011 DDR2, 3'b111 DDR3) |
| cmd_valid | input | 1 | Scheduler offers a command |
| cmd_ready | output | 1 | Stage accepts the offered command at this edge |
| cmd_op | input | OPW | Command bits to launch |
| cmd_addr | input | AW | Row/column address |
| cmd_bank | input | BAW | Bank address |
| cmd_cs | input | CSIW | Index of the chip select to strobe |
| dram_cmd | output | OPW | Command pins (all ones when idle) |
| dram_addr | output | AW | Address pins |
| dram_ba | output | BAW | Bank pins |
| dram_cs_n | output | NCS | Active-low chip selects |
| cfg_error | output | 1 | Sticky illegal-configuration flag |

## Verification
The assertions assume that the configuration inputs change only between launch windows, that the scheduler never offers the idle command code (all ones), and that `cmd_cs` is below NCS. The bench writes the configuration only while the pins are idle and uses command codes other than all ones. It drives the handshake only at falling edges, so every accept follows from the `cmd_ready` value it sampled. Illegal configurations are applied right after a reset, so that each check sees the sticky flag rise on its own.

// File: rtl/cmdl_pkg.sv
package cmdl_pkg;

  localparam logic [2:0] MEMTYPE_DDR2 = 3'b011;
  localparam logic [2:0] MEMTYPE_DDR3 = 3'b111;

  // Number of clocks a command occupies the pins for the chosen timing mode.
  function automatic logic [1:0] launch_span(input logic t2, input logic t3);
    if (t3)      return 2'd3;
    else if (t2) return 2'd2;
    else         return 2'd1;
  endfunction

  // Cross-field legality of the timing, width, burst and memory-type settings.
  function automatic logic cfg_is_legal(input logic t2, input logic t3,
                                        input logic bus32, input logic burst8,
                                        input logic [2:0] memtype);
    logic ok;
    ok = 1'b1;
    if (t2 && t3) ok = 1'b0;
    if ((t2 || t3) && bus32 && !burst8) ok = 1'b0;
    if (memtype == MEMTYPE_DDR2 && burst8) ok = 1'b0;
    if (memtype == MEMTYPE_DDR3 && (bus32 != burst8)) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/cmdl_cfg_check.sv
module cmdl_cfg_check
  import cmdl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       t2,
  input  logic       t3,
  input  logic       bus32,
  input  logic       burst8,
  input  logic [2:0] memtype,
  output logic       cfg_ok,
  output logic [1:0] span,
  output logic       cfg_error
);

  logic err_q;

  assign cfg_ok    = cfg_is_legal(t2, t3, bus32, burst8, memtype);
  assign span      = launch_span(t2, t3);
  assign cfg_error = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (!cfg_ok) err_q <= 1'b1;
  end

endmodule

// File: rtl/cmdl_window_ctrl.sv
module cmdl_window_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       cfg_ok,
  input  logic [1:0] span,
  output logic       cmd_ready,
  output logic       accept,
  output logic       win_active,
  output logic       win_last,
  output logic       cs_fire_next
);

  logic       active_q;
  logic [1:0] remain_q;

  assign win_active = active_q;
  assign win_last   = active_q && (remain_q == 2'd0);
  assign cmd_ready  = cfg_ok && (!active_q || win_last);
  assign accept     = cmd_valid && cmd_ready;

  // Chip select strobes in the clock that will be the window's last one.
  assign cs_fire_next = (accept && span == 2'd1) ||
                        (active_q && remain_q == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      remain_q <= 2'd0;
    end else if (accept) begin
      active_q <= 1'b1;
      remain_q <= span - 2'd1;
    end else if (win_last) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      remain_q <= remain_q - 2'd1;
    end
  end

endmodule

// File: rtl/cmdl_pin_drive.sv
module cmdl_pin_drive #(
  parameter int          OPW     = 3,
  parameter int          AW      = 14,
  parameter int          BAW     = 3,
  parameter int          NCS     = 2,
  parameter int          CSIW    = 1,
  parameter logic [OPW-1:0] IDLE_OP = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            win_last,
  input  logic            cs_fire_next,
  input  logic [OPW-1:0]  cmd_op,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [BAW-1:0]  cmd_bank,
  input  logic [CSIW-1:0] cmd_cs,
  output logic [OPW-1:0]  dram_cmd,
  output logic [AW-1:0]   dram_addr,
  output logic [BAW-1:0]  dram_ba,
  output logic [NCS-1:0]  dram_cs_n
);

  logic [CSIW-1:0] cs_idx_q;
  logic [CSIW-1:0] cs_sel;
  logic [NCS-1:0]  cs_dec;

  assign cs_sel = accept ? cmd_cs : cs_idx_q;

  for (genvar g = 0; g < NCS; g++) begin : g_cs_dec
    assign cs_dec[g] = (cs_sel == CSIW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dram_cmd  <= IDLE_OP;
      dram_addr <= '0;
      dram_ba   <= '0;
      dram_cs_n <= '1;
      cs_idx_q  <= '0;
    end else begin
      if (accept) begin
        dram_cmd  <= cmd_op;
        dram_addr <= cmd_addr;
        dram_ba   <= cmd_bank;
        cs_idx_q  <= cmd_cs;
      end else if (win_last) begin
        dram_cmd  <= IDLE_OP;
      end
      dram_cs_n <= cs_fire_next ? ~cs_dec : '1;
    end
  end

endmodule

// File: rtl/dram_cmd_launch.sv
module dram_cmd_launch #(
  parameter int OPW  = 3,
  parameter int AW   = 14,
  parameter int BAW  = 3,
  parameter int NCS  = 2,
  localparam int CSIW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_t2,
  input  logic            cfg_t3,
  input  logic            cfg_bus32,
  input  logic            cfg_burst8,
  input  logic [2:0]      cfg_memtype,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [OPW-1:0]  cmd_op,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [BAW-1:0]  cmd_bank,
  input  logic [CSIW-1:0] cmd_cs,
  output logic [OPW-1:0]  dram_cmd,
  output logic [AW-1:0]   dram_addr,
  output logic [BAW-1:0]  dram_ba,
  output logic [NCS-1:0]  dram_cs_n,
  output logic            cfg_error
);

  localparam logic [OPW-1:0] IDLE_OP = '1;

  logic       cfg_ok;
  logic [1:0] span;
  logic       accept;
  logic       win_active;
  logic       win_last;
  logic       cs_fire_next;

  cmdl_cfg_check u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .t2        (cfg_t2),
    .t3        (cfg_t3),
    .bus32     (cfg_bus32),
    .burst8    (cfg_burst8),
    .memtype   (cfg_memtype),
    .cfg_ok    (cfg_ok),
    .span      (span),
    .cfg_error (cfg_error)
  );

  cmdl_window_ctrl u_win (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cfg_ok       (cfg_ok),
    .span         (span),
    .cmd_ready    (cmd_ready),
    .accept       (accept),
    .win_active   (win_active),
    .win_last     (win_last),
    .cs_fire_next (cs_fire_next)
  );

  cmdl_pin_drive #(
    .OPW     (OPW),
    .AW      (AW),
    .BAW     (BAW),
    .NCS     (NCS),
    .CSIW    (CSIW),
    .IDLE_OP (IDLE_OP)
  ) u_pins (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .win_last     (win_last),
    .cs_fire_next (cs_fire_next),
    .cmd_op       (cmd_op),
    .cmd_addr     (cmd_addr),
    .cmd_bank     (cmd_bank),
    .cmd_cs       (cmd_cs),
    .dram_cmd     (dram_cmd),
    .dram_addr    (dram_addr),
    .dram_ba      (dram_ba),
    .dram_cs_n    (dram_cs_n)
  );

endmodule

// File: rtl/dram_cmd_launch_chk.sv
module dram_cmd_launch_chk #(
  parameter int OPW = 3,
  parameter int AW  = 14,
  parameter int NCS = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic [OPW-1:0] dram_cmd,
  input logic [AW-1:0]  dram_addr,
  input logic [NCS-1:0] dram_cs_n,
  input logic           cfg_error,
  input logic           cfg_ok,
  input logic           win_active,
  input logic           win_last
);

  p_accept_opens_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> win_active);

  p_cs_only_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cs_n != {NCS{1'b1}}) |-> win_last);

  p_pins_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_active && !win_last |=> $stable(dram_addr) && $stable(dram_cmd));

  p_ready_mid_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_active && !win_last |-> !cmd_ready);

  p_idle_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_active |-> (dram_cs_n == {NCS{1'b1}}) && (dram_cmd == {OPW{1'b1}}));

  p_single_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dram_cs_n));

  p_illegal_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok |=> cfg_error);

  p_illegal_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok |-> !cmd_ready);

  p_error_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |=> cfg_error);

endmodule

bind dram_cmd_launch dram_cmd_launch_chk #(
  .OPW (OPW),
  .AW  (AW),
  .NCS (NCS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .dram_cmd   (dram_cmd),
  .dram_addr  (dram_addr),
  .dram_cs_n  (dram_cs_n),
  .cfg_error  (cfg_error),
  .cfg_ok     (cfg_ok),
  .win_active (win_active),
  .win_last   (win_last)
);

// File: tb/dram_cmd_launch_tb.sv
`timescale 1ns/1ps
module dram_cmd_launch_tb;

  localparam int OPW = 3;
  localparam int AW  = 14;
  localparam int BAW = 3;
  localparam int NCS = 2;
  localparam int CSIW = 1;

  typedef struct packed {
    logic [OPW-1:0] op;
    logic [AW-1:0]  addr;
    logic [BAW-1:0] ba;
    logic [NCS-1:0] cs_n;
    logic [1:0]     span;
  } pin_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_t2 = 1'b0, cfg_t3 = 1'b0, cfg_bus32 = 1'b0, cfg_burst8 = 1'b0;
  logic [2:0] cfg_memtype = 3'b111;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [OPW-1:0]  cmd_op = '0;
  logic [AW-1:0]   cmd_addr = '0;
  logic [BAW-1:0]  cmd_bank = '0;
  logic [CSIW-1:0] cmd_cs = '0;
  logic [OPW-1:0]  dram_cmd;
  logic [AW-1:0]   dram_addr;
  logic [BAW-1:0]  dram_ba;
  logic [NCS-1:0]  dram_cs_n;
  logic cfg_error;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  pin_item_t sb_q[$];

  always #10 clk = ~clk;

  dram_cmd_launch #(.OPW(OPW), .AW(AW), .BAW(BAW), .NCS(NCS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_t2(cfg_t2), .cfg_t3(cfg_t3), .cfg_bus32(cfg_bus32),
    .cfg_burst8(cfg_burst8), .cfg_memtype(cfg_memtype),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_bank(cmd_bank), .cmd_cs(cmd_cs),
    .dram_cmd(dram_cmd), .dram_addr(dram_addr), .dram_ba(dram_ba),
    .dram_cs_n(dram_cs_n), .cfg_error(cfg_error)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected snapshot per clock that carries a command.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (dram_cmd != {OPW{1'b1}}) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R10 unexpected command on pins", 64'(dram_cmd), 64'h7);
        end else begin
          pin_item_t e;
          e = sb_q.pop_front();
          check({dram_cmd, dram_addr, dram_ba, dram_cs_n} == {e.op, e.addr, e.ba, e.cs_n},
                e.span == 2'd3 ? "R3 pins" : (e.span == 2'd2 ? "R2 pins" : "R1 pins"),
                64'({dram_cmd, dram_addr, dram_ba, dram_cs_n}),
                64'({e.op, e.addr, e.ba, e.cs_n}));
        end
      end else begin
        check(dram_cs_n == {NCS{1'b1}}, "R5 idle chip select", 64'(dram_cs_n), 64'h3);
      end
    end
  end

  // Driver: offers a command at a falling edge and queues the expected pin clocks.
  task automatic send(input logic [OPW-1:0] op, input logic [AW-1:0] a,
                      input logic [BAW-1:0] b, input logic [CSIW-1:0] cs);
    int span;
    span = cfg_t3 ? 3 : (cfg_t2 ? 2 : 1);
    cmd_op = op; cmd_addr = a; cmd_bank = b; cmd_cs = cs; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    for (int k = 1; k <= span; k++) begin
      pin_item_t e;
      e.op = op; e.addr = a; e.ba = b; e.span = 2'(span);
      e.cs_n = (k == span) ? ~(NCS'(1) << cs) : {NCS{1'b1}};
      sb_q.push_back(e);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Called in the first clock of a window: ready low until the last clock (R4).
  task automatic ready_seq(input int span);
    for (int k = 1; k < span; k++) begin
      check(cmd_ready == 1'b0, "R4 ready low mid-window", 64'(cmd_ready), 64'h0);
      @(negedge clk);
    end
    check(cmd_ready == 1'b1, "R4 ready high in last clock", 64'(cmd_ready), 64'h1);
  endtask

  task automatic set_default_cfg();
    cfg_t2 = 1'b0; cfg_t3 = 1'b0; cfg_bus32 = 1'b0; cfg_burst8 = 1'b0;
    cfg_memtype = 3'b111;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(dram_cs_n == {NCS{1'b1}}, "R11 reset cs", 64'(dram_cs_n), 64'h3);
    check(dram_cmd == {OPW{1'b1}}, "R11 reset cmd", 64'(dram_cmd), 64'h7);
    check(cfg_error == 1'b0, "R11 reset error", 64'(cfg_error), 64'h0);
    check(cmd_ready == 1'b1, "R11 reset ready", 64'(cmd_ready), 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_case(input logic t2, input logic t3, input logic b32,
                          input logic b8, input logic [2:0] mt,
                          input bit legal, input string tag);
    do_reset();
    cfg_t2 = t2; cfg_t3 = t3; cfg_bus32 = b32; cfg_burst8 = b8; cfg_memtype = mt;
    cmd_op = 3'b010; cmd_addr = 14'h1234; cmd_valid = legal ? 1'b0 : 1'b1;
    #1;
    check(cmd_ready == legal, {tag, " ready"}, 64'(cmd_ready), 64'(legal));
    @(negedge clk);
    check(cfg_error == !legal, {tag, " error flag"}, 64'(cfg_error), 64'(!legal));
    @(negedge clk);
    check(dram_cmd == {OPW{1'b1}}, "R10 no launch while illegal", 64'(dram_cmd), 64'h7);
    cmd_valid = 1'b0;
    set_default_cfg();
    #1;
    check(cmd_ready == 1'b1, "R10 ready returns", 64'(cmd_ready), 64'h1);
    @(negedge clk);
    check(cfg_error == !legal, "R10 error sticky", 64'(cfg_error), 64'(!legal));
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    set_default_cfg();
    @(negedge clk);
    do_reset();

    // R1: 1T, back-to-back, both chip selects
    send(3'b001, 14'h0111, 3'd1, 1'b0);
    ready_seq(1);
    send(3'b010, 14'h2222, 3'd2, 1'b1);
    send(3'b100, 14'h3333, 3'd3, 1'b0);
    repeat (3) @(negedge clk);

    // R2: 2T
    cfg_t2 = 1'b1;
    send(3'b011, 14'h0444, 3'd4, 1'b1);
    ready_seq(2);
    send(3'b000, 14'h0555, 3'd5, 1'b0);
    send(3'b101, 14'h3fff, 3'd7, 1'b1);
    repeat (4) @(negedge clk);

    // R3: 3T
    cfg_t2 = 1'b0; cfg_t3 = 1'b1;
    send(3'b110, 14'h0666, 3'd6, 1'b0);
    ready_seq(3);
    send(3'b001, 14'h0000, 3'd0, 1'b1);
    send(3'b010, 14'h2aaa, 3'd2, 1'b0);
    repeat (5) @(negedge clk);
    check(sb_q.size() == 0, "R5 scoreboard drained", 64'(sb_q.size()), 64'h0);
    set_default_cfg();

    cfg_case(1'b1, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, "R6 both enables");
    cfg_case(1'b1, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, "R7 2T 32-bit 4-beat");
    cfg_case(1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, "R7 3T 32-bit 4-beat");
    cfg_case(1'b1, 1'b0, 1'b1, 1'b1, 3'b000, 1'b1, "R7 2T 32-bit 8-beat legal");
    cfg_case(1'b0, 1'b0, 1'b0, 1'b1, 3'b011, 1'b0, "R8 DDR2 8-beat");
    cfg_case(1'b0, 1'b0, 1'b1, 1'b0, 3'b011, 1'b1, "R8 DDR2 4-beat legal");
    cfg_case(1'b0, 1'b0, 1'b1, 1'b0, 3'b111, 1'b0, "R9 DDR3 32-bit 4-beat");
    cfg_case(1'b0, 1'b0, 1'b0, 1'b1, 3'b111, 1'b0, "R9 DDR3 64-bit 8-beat");
    cfg_case(1'b0, 1'b0, 1'b1, 1'b1, 3'b111, 1'b1, "R9 DDR3 32-bit 8-beat legal");

    // R10: commands flow again after an illegal spell
    send(3'b001, 14'h0777, 3'd1, 1'b1);
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R10 launch after recovery", 64'(sb_q.size()), 64'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule